// File: doc/BRIEF.md
# I2C Channel Select Controller

This block is the digital front end of a two-way bus multiplexer. It acts as an I2C target on an upstream bus and holds one control byte. A bus controller writes that byte to choose which of two downstream bus segments gets connected: segment 0, segment 1, or neither. The block outputs a one-hot enable pair that drives the external pass gates. SCL and SDA reach the block as raw pin levels. Both are sampled by the system clock through a two-stage synchroniser. SDA is driven back only through an open-drain pull-low enable.

A written selection is held in a pending register and copied to the active register only when a STOP is seen. The enables therefore switch only while both bus lines are idle high. A write with several data bytes leaves the last byte in the register. A read returns the full stored byte and ends when the controller answers with a NACK. The 7-bit target address is a parameter.

The protocol machine has eight states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: pulls SDA low when the address matches.
- `ST_WDATA`: shifts in a data byte.
- `ST_WACK`: acknowledges the data byte and stores it.
- `ST_RDATA`: shifts out the stored byte.
- `ST_RACK`: samples the controller's ACK or NACK.
- `ST_SKIP`: stays silent until the next START or STOP.

Transitions:
- START moves any state to `ST_ADDR`, and STOP moves any state to `ST_IDLE`.
- The eighth-bit falling edge moves `ST_ADDR` to `ST_ADDR_ACK` when the address matches, and to `ST_SKIP` when it does not.
- The ninth-bit falling edge moves `ST_ADDR_ACK` to `ST_RDATA` for a read and to `ST_WDATA` for a write.
- `ST_WDATA` and `ST_WACK` alternate on each eighth and ninth falling edge.
- `ST_RDATA` moves to `ST_RACK` after eight bits. `ST_RACK` returns to `ST_RDATA` on an ACK and moves to `ST_SKIP` on a NACK.

Top module: `chan_select_ctrl`

## Requirements
- R1: After reset, `ch_en` is 2'b00, `sda_oe` is 0, and a read of the control byte returns 8'h00.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START in the middle of a byte restarts address reception. A STOP in the middle of a data byte stores nothing.
- R3: The first byte after START is the 7-bit address, MSB first, followed by a direction bit (1 = read, 0 = write). On a match, the block holds SDA low for the whole high phase of the ninth clock.
- R4: On an address mismatch, the block gives no acknowledge and ignores every bit until the next START or STOP. Neither the stored byte nor the enables change.
- R5: On a write, every data byte is acknowledged on its ninth clock and stored. When several bytes arrive, the last one is kept.
- R6: On a read, the stored 8-bit byte is shifted out MSB first and is repeated after each controller ACK. After a controller NACK, SDA is released until the next START or STOP.
- R7: Only bits [1:0] of the byte select the channel. 2'b10 gives `ch_en` = 2'b01 (segment 0 on bit 0), 2'b11 gives 2'b10 (segment 1 on bit 1), and 2'b00 or 2'b01 gives 2'b00.
- R8: A new selection reaches `ch_en` only after a STOP. A repeated START does not apply it.
- R9: At most one bit of `ch_en` is set at any time.
- R10: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| scl_i | input | 1 | Raw SCL level from the upstream bus |
| sda_i | input | 1 | Raw SDA level from the upstream bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| ch_en | output | 2 | One-hot downstream segment enables |

## Verification
- A wrong protocol state shows up on `sda_oe` within the next byte:
  - a missing acknowledge on the ninth clock;
  - an acknowledge on a foreign address;
  - SDA held low past a NACK, which would block the STOP that follows.
- A wrong bit count shifts the read-back data by one position. The bench sees this in the first byte read after the fault.
- A wrong pending or active register shows up as a wrong `ch_en` value sampled a few cycles after STOP, or as an enable that moves before STOP. Read-back exposes a bad pending byte without waiting for a STOP.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } bus_state_e;

    // Two select bits to one-hot enables: 10 -> segment 0, 11 -> segment 1
    function automatic logic [1:0] sel_to_en(input logic [1:0] sel);
        logic [1:0] en;
        en = 2'b00;
        if (sel[1]) begin
            en[sel[0]] = 1'b1;
        end
        return en;
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bus_event_det.sv
module bus_event_det (
    input  logic clk,
    input  logic rst,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end

    // R2
    start_stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_evt && stop_evt));
endmodule

// File: rtl/bus_target_fsm.sv
module bus_target_fsm
    import chsel_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h70,
    parameter int         BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

    bus_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] shreg_q, shreg_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              stb_q, stb_d;

    // Next-state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shreg_d = shreg_q;
        tx_d    = tx_q;
        stb_d   = 1'b0;
        if (start_evt) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL_CNT) begin
                        state_d = (shreg_q[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (shreg_q[0]) begin
                            state_d = ST_RDATA;
                            tx_d    = rd_data;
                        end else begin
                            state_d = ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[BYTE_W-2:0], sda_s};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == FULL_CNT) begin
                        state_d = ST_WACK;
                        stb_d   = 1'b1;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                        cnt_d   = '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt_q == LAST_TX) begin
                            state_d = ST_RACK;
                        end else begin
                            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        shreg_d[0] = sda_s;
                    end else if (scl_fall) begin
                        if (shreg_q[0]) begin
                            state_d = ST_SKIP;
                        end else begin
                            state_d = ST_RDATA;
                            tx_d    = rd_data;
                            cnt_d   = '0;
                        end
                    end
                end
                ST_SKIP: ;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            tx_q    <= '0;
            stb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shreg_q <= shreg_d;
            tx_q    <= tx_d;
            stb_q   <= stb_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_WACK: sda_oe = 1'b1;
            ST_RDATA:             sda_oe = ~tx_q[BYTE_W-1];
            default:              sda_oe = 1'b0;
        endcase
        wr_stb  = stb_q;
        wr_data = shreg_q;
    end

    // R2
    start_to_addr_chk: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> state_q == ST_ADDR);
    // R2
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> state_q == ST_IDLE);
    // R4
    ack_only_match_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_ADDR_ACK |-> shreg_q[BYTE_W-1:1] == DEV_ADDR);
    // R10
    oe_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);
endmodule

// File: rtl/select_regs.sv
module select_regs
    import chsel_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              apply,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        ch_en
);
    logic [BYTE_W-1:0] pending_q;
    logic [SEL_W-1:0]  active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            if (wr_stb) begin
                pending_q <= wr_data;
            end
            if (apply) begin
                active_q <= pending_q[SEL_W-1:0];
            end
        end
    end

    assign rd_data = pending_q;
    assign ch_en   = sel_to_en(active_q);

    // R9
    en_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_en));
    // R8
    en_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> $past(apply));
    // R5
    store_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> rd_data == $past(wr_data));
endmodule

// File: rtl/chan_select_ctrl.sv
module chan_select_ctrl #(
    parameter logic [6:0] DEV_ADDR    = 7'h70,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [1:0] ch_en
);
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;

    logic              scl_s, sda_s;
    logic              scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_data, rd_data;

    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst(rst), .d(scl_i), .q(scl_s));
    line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst(rst), .d(sda_i), .q(sda_s));

    bus_event_det u_det (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt));

    bus_target_fsm #(.DEV_ADDR(DEV_ADDR), .BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .sda_oe(sda_oe),
        .wr_stb(wr_stb), .wr_data(wr_data));

    select_regs #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .apply(stop_evt), .rd_data(rd_data), .ch_en(ch_en));
endmodule

// File: tb/chan_select_ctrl_test.sv
module chan_select_ctrl_test;
    localparam logic [6:0] ADDR = 7'h70;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [1:0] ch_en;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int n_oe_viol = 0;
    logic [7:0] exp_pend = 8'h00;
    logic [1:0] exp_sel = 2'b00;

    always #2.5 clk = ~clk;

    chan_select_ctrl #(.DEV_ADDR(ADDR)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .ch_en(ch_en));

    function automatic logic [1:0] exp_en(input logic [1:0] s);
        return (s == 2'b10) ? 2'b01 : (s == 2'b11) ? 2'b10 : 2'b00;
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 monitor: sda_oe may only move while SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe != oe_prev && scl_m) n_oe_viol++;
        oe_prev <= sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
        exp_sel = exp_pend[1:0];
    endtask

    task automatic clock_bit(input logic b, output logic s_early, output logic s_late);
        sda_m = b; tick(Q);
        scl_m = 1'b1; tick(2);
        s_early = sda_line;
        tick(2*Q - 3);
        s_late = sda_line;
        tick(1);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic acked);
        logic e, l;
        for (int i = 7; i >= 0; i--) clock_bit(d[i], e, l);
        clock_bit(1'b1, e, l);
        acked = !e && !l;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        logic e, l;
        d = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clock_bit(1'b1, e, l);
            d = {d[6:0], l};
        end
        clock_bit(nack, e, l);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n, input logic do_stop);
        logic ack;
        logic match;
        logic [7:0] bytes [3];
        bytes[0] = d0; bytes[1] = d1; bytes[2] = d2;
        match = (a == ADDR);
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack == match, match ? "R3 write address ack" : "R4 mismatch no ack", ack, match);
        for (int i = 0; i < n; i++) begin
            send_byte(bytes[i], ack);
            check(ack == match, match ? "R5 data ack" : "R4 data ignored", ack, match);
            if (match) exp_pend = bytes[i];
        end
        if (do_stop) bus_stop();
    endtask

    task automatic rd_txn(input int n);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        check(ack, "R3 read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i == n - 1, d);
            check(d == exp_pend, "R6 read data", d, exp_pend);
        end
        check(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
        bus_stop();
    endtask

    task automatic check_en(input string tag);
        check(ch_en == exp_en(exp_sel), tag, ch_en, exp_en(exp_sel));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack, e, l;
        logic [7:0] d;
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0042);
        tick(6);
        rst = 1'b0;
        tick(4);

        // R1 reset state
        check(ch_en == 2'b00, "R1 reset enables", ch_en, 0);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        rd_txn(1);
        check_en("R1 enables after empty read");

        // R8: selection deferred past a repeated START
        wr_txn(ADDR, 8'h02, 8'h00, 8'h00, 1, 1'b0);
        check(ch_en == 2'b00, "R8 no change before stop", ch_en, 0);
        bus_start();
        send_byte({ADDR, 1'b1}, ack);
        recv_byte(1'b1, d);
        check(d == 8'h02, "R6 read on repeated start", d, 8'h02);
        check(ch_en == 2'b00, "R8 repeated start does not apply", ch_en, 0);
        bus_stop();
        check_en("R7 sel 10 -> segment 0");

        // R5: several bytes, last one kept
        wr_txn(ADDR, 8'h02, 8'hA1, 8'h03, 3, 1'b0);
        check(ch_en == 2'b01, "R8 held during multi-byte write", ch_en, 2'b01);
        bus_stop();
        check_en("R5 last byte applies");
        rd_txn(2);

        // R4: foreign address
        wr_txn(ADDR ^ 7'h01, 8'h02, 8'h00, 8'h00, 1, 1'b1);
        check_en("R4 enables unchanged");
        rd_txn(1);

        // R2: START mid-address restarts reception
        bus_start();
        for (int i = 0; i < 4; i++) clock_bit(i[0], e, l);
        wr_txn(ADDR, 8'h02, 8'h00, 8'h00, 1, 1'b1);
        check_en("R2 restart then write");

        // R2: STOP mid-data stores nothing
        bus_start();
        send_byte({ADDR, 1'b0}, ack);
        for (int i = 0; i < 3; i++) clock_bit(1'b1, e, l);
        bus_stop();
        check_en("R2 stop mid byte");
        rd_txn(1);

        // R7: upper bits ignored, 01 selects none
        wr_txn(ADDR, 8'hFF, 8'h00, 8'h00, 1, 1'b1);
        check_en("R7 sel 11 -> segment 1");
        wr_txn(ADDR, 8'hFD, 8'h00, 8'h00, 1, 1'b1);
        check_en("R7 sel 01 -> none");
        wr_txn(ADDR, 8'hFE, 8'h00, 8'h00, 1, 1'b1);
        check_en("R7 sel 10 upper bits set");
        wr_txn(ADDR, 8'h00, 8'h00, 8'h00, 1, 1'b1);
        check_en("R7 sel 00 -> none");

        // Random mix
        for (int it = 0; it < 20; it++) begin
            logic [6:0] a;
            int n;
            a = ($urandom % 4 != 0) ? ADDR : (ADDR ^ 7'(1 << ($urandom % 7)));
            n = 1 + ($urandom % 3);
            wr_txn(a, 8'($urandom), 8'($urandom), 8'($urandom), n, 1'b1);
            check_en("R7 R8 random write");
            check(ch_en != 2'b11, "R9 one-hot", ch_en, 0);
            rd_txn(1 + ($urandom % 2));
        end

        check(n_oe_viol == 0, "R10 sda_oe moved while SCL high", n_oe_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule